// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports whether the first is below, equal to or above the second, on three separate output lines. It is built from 4-bit slices. Each slice works out its own nibble's relation with a chain of single-bit cells running from the most significant bit down. It then merges that local relation with a three-line relation handed up from the slice below it. The local result decides the answer when the nibbles differ. When they are equal, the lower slice's relation passes through unchanged.

The top level chains a parameterised number of slices. The lowest slice sits at the bottom bits of the words. The chain's own relation inputs are brought out to ports, so a whole chain can in turn be cascaded. For a stand-alone comparison those inputs are driven with equal = 1, below = 0 and above = 0. The block is purely combinational.

Top module: `cmpChain`

## Requirements
- R1: `ltOut` is 1 when `aIn < bIn` (unsigned), or when `aIn == bIn` and `ltIn` is 1; otherwise it is 0.
- R2: `gtOut` is 1 when `aIn > bIn` (unsigned), or when `aIn == bIn` and `gtIn` is 1; otherwise it is 0.
- R3: `eqOut` is 1 only when `aIn == bIn` and `eqIn` is 1.
- R4: When the relation inputs carry a legal one-hot code (exactly one of `ltIn`, `eqIn`, `gtIn` is 1), exactly one of the three outputs is 1.
- R5: With the relation inputs at equal = 1, below = 0, above = 0, the outputs give the plain unsigned comparison of the full words. Bits [3:0] form the least significant slice, and each higher nibble overrides all lower ones whenever it differs.
- R6: The number of slices is set by parameter `NUM_SLICES` (default 2), and the word ports are 4·`NUM_SLICES` bits wide. A difference in the top bit alone decides the result.
- R7: When the words differ, the relation inputs have no effect, even if they are not one-hot. When the words are equal, the outputs copy the relation inputs bit for bit, illegal codes (all zero, several set) included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aIn | input | 4·NUM_SLICES | First unsigned operand |
| bIn | input | 4·NUM_SLICES | Second unsigned operand |
| ltIn | input | 1 | Below relation from a less significant stage |
| eqIn | input | 1 | Equal relation from a less significant stage |
| gtIn | input | 1 | Above relation from a less significant stage |
| ltOut | output | 1 | aIn below bIn |
| eqOut | output | 1 | aIn equal to bIn |
| gtOut | output | 1 | aIn above bIn |

## Verification
A single-slice chain is driven with every pair of nibbles under all eight relation-input codes. This separates the local decision from the pass-through path, and it shows that illegal codes are copied only on equality. An 8-bit chain receives random word pairs and pairs that differ only in the low nibble. The low-nibble pairs show that the lower slice decides only when the upper nibbles match. Directed top-bit and all-ones cases show that the full port width takes part in the comparison.

// File: rtl/cmpPkg.sv
package cmpPkg;
  // Three-line relation passed between stages.
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } cmpResT;

  localparam cmpResT SEED_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
endpackage

// File: rtl/cmpBitCell.sv
// One bit position of the iterative comparator. The relation arrives from the
// more significant side; this bit decides only if everything above was equal.
module cmpBitCell
  import cmpPkg::*;
(
  input  logic   aBit,
  input  logic   bBit,
  input  cmpResT hiRes,
  output cmpResT loRes
);
  logic same;

  always_comb begin
    same     = ~(aBit ^ bBit);
    loRes.eq = hiRes.eq & same;
    loRes.gt = hiRes.gt | (hiRes.eq & aBit & ~bBit);
    loRes.lt = hiRes.lt | (hiRes.eq & ~aBit & bBit);
  end
endmodule

// File: rtl/cmpMerge.sv
// Combines a slice's own relation with the relation from the slice below.
module cmpMerge
  import cmpPkg::*;
(
  input  cmpResT localRes,
  input  cmpResT cascRes,
  output cmpResT mergedRes
);
  always_comb begin
    mergedRes.lt = localRes.lt | (localRes.eq & cascRes.lt);
    mergedRes.gt = localRes.gt | (localRes.eq & cascRes.gt);
    mergedRes.eq = localRes.eq & cascRes.eq;
  end
endmodule

// File: rtl/cmpSlice.sv
module cmpSlice
  import cmpPkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] aNib,
  input  logic [SLICE_W-1:0] bNib,
  input  cmpResT             cascIn,
  output cmpResT             cascOut
);
  // bitLink[SLICE_W] is the seed above the MSB; bitLink[0] is the local result.
  cmpResT bitLink [SLICE_W:0];

  assign bitLink[SLICE_W] = SEED_EQUAL;

  for (genvar i = SLICE_W - 1; i >= 0; i--) begin : gBit
    cmpBitCell u_cell (
      .aBit (aNib[i]),
      .bBit (bNib[i]),
      .hiRes(bitLink[i+1]),
      .loRes(bitLink[i])
    );
  end

  cmpMerge u_merge (
    .localRes (bitLink[0]),
    .cascRes  (cascIn),
    .mergedRes(cascOut)
  );
endmodule

// File: rtl/cmpChain.sv
module cmpChain
  import cmpPkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 2
) (
  input  logic [SLICE_W*NUM_SLICES-1:0] aIn,
  input  logic [SLICE_W*NUM_SLICES-1:0] bIn,
  input  logic                          ltIn,
  input  logic                          eqIn,
  input  logic                          gtIn,
  output logic                          ltOut,
  output logic                          eqOut,
  output logic                          gtOut
);
  // link[0] enters the least significant slice; link[NUM_SLICES] leaves the top.
  cmpResT link [NUM_SLICES:0];

  assign link[0] = '{lt: ltIn, eq: eqIn, gt: gtIn};

  for (genvar k = 0; k < NUM_SLICES; k++) begin : gSlice
    cmpSlice #(.SLICE_W(SLICE_W)) u_slice (
      .aNib   (aIn[k*SLICE_W +: SLICE_W]),
      .bNib   (bIn[k*SLICE_W +: SLICE_W]),
      .cascIn (link[k]),
      .cascOut(link[k+1])
    );
  end

  assign ltOut = link[NUM_SLICES].lt;
  assign eqOut = link[NUM_SLICES].eq;
  assign gtOut = link[NUM_SLICES].gt;
endmodule

// File: rtl/cmpChainChecker.sv
module cmpChainChecker #(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 2
) (
  input logic [SLICE_W*NUM_SLICES-1:0] aIn,
  input logic [SLICE_W*NUM_SLICES-1:0] bIn,
  input logic                          ltIn,
  input logic                          eqIn,
  input logic                          gtIn,
  input logic                          ltOut,
  input logic                          eqOut,
  input logic                          gtOut
);
  always_comb begin
    assert_lt_R1: assert (ltOut == ((aIn < bIn) || ((aIn == bIn) && ltIn)))
      else $error("ltOut wrong");
    assert_gt_R2: assert (gtOut == ((aIn > bIn) || ((aIn == bIn) && gtIn)))
      else $error("gtOut wrong");
    assert_eq_R3: assert (eqOut == ((aIn == bIn) && eqIn))
      else $error("eqOut wrong");
    if ($onehot({ltIn, eqIn, gtIn}))
      assert_onehot_R4: assert ($countones({ltOut, eqOut, gtOut}) == 1)
        else $error("outputs not one-hot");
    if (aIn != bIn)
      assert_ignore_R7: assert (!eqOut && (ltOut != gtOut))
        else $error("relation inputs leaked");
  end
endmodule

bind cmpChain cmpChainChecker #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chk (
  .aIn(aIn), .bIn(bIn), .ltIn(ltIn), .eqIn(eqIn), .gtIn(gtIn),
  .ltOut(ltOut), .eqOut(eqOut), .gtOut(gtOut)
);

// File: tb/cmpChain_tb.sv
module cmpChain_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Wide chain (two slices)
  logic [7:0] wA = '0, wB = '0;
  logic [2:0] wCas = 3'b010;  // {lt, eq, gt}
  logic [2:0] wRes;
  // Single slice for the exhaustive sweep
  logic [3:0] oA = '0, oB = '0;
  logic [2:0] oCas = 3'b010;
  logic [2:0] oRes;

  cmpChain #(.SLICE_W(4), .NUM_SLICES(2)) u_dut (
    .aIn(wA), .bIn(wB), .ltIn(wCas[2]), .eqIn(wCas[1]), .gtIn(wCas[0]),
    .ltOut(wRes[2]), .eqOut(wRes[1]), .gtOut(wRes[0])
  );

  cmpChain #(.SLICE_W(4), .NUM_SLICES(1)) u_one (
    .aIn(oA), .bIn(oB), .ltIn(oCas[2]), .eqIn(oCas[1]), .gtIn(oCas[0]),
    .ltOut(oRes[2]), .eqOut(oRes[1]), .gtOut(oRes[0])
  );

  function automatic logic [2:0] refCmp(int unsigned a, int unsigned b, logic [2:0] c);
    if (a < b) return 3'b100;
    if (a > b) return 3'b001;
    return c;
  endfunction

  task automatic checkOne(string tag, logic [2:0] got, logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic wideCheck(string tag, logic [7:0] a, logic [7:0] b, logic [2:0] c);
    @(negedge clk);
    wA = a; wB = b; wCas = c;
    settle();
    checkOne(tag, wRes, refCmp(a, b, c));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    settle();
    // Initial state: zero words, seed code -> equal
    checkOne("R3 initial", wRes, 3'b010);
    checkOne("R3 initial slice", oRes, 3'b010);

    // Exhaustive single slice, all eight relation-input codes
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          oA = 4'(a); oB = 4'(b); oCas = 3'(c);
          settle();
          if (a < b)       checkOne("R1", oRes, refCmp(a, b, 3'(c)));
          else if (a > b)  checkOne("R2", oRes, refCmp(a, b, 3'(c)));
          else if ($onehot(3'(c))) checkOne("R3", oRes, refCmp(a, b, 3'(c)));
          else             checkOne("R7", oRes, refCmp(a, b, 3'(c)));
          if ($onehot(3'(c)))
            checkOne("R4", {1'b0, 2'($countones(oRes))}, 3'd1);
          if (a != b && !$onehot(3'(c)))
            checkOne("R7 ignored", oRes, (a < b) ? 3'b100 : 3'b001);
        end
      end
    end

    // Chain: high nibble equal, low nibble decides
    for (int i = 0; i < 256; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      wideCheck("R5 low decides", {r[7:4], r[3:0]}, {r[7:4], 4'(i)}, 3'b010);
    end
    // Chain: random words
    for (int i = 0; i < 1500; i++)
      wideCheck("R5 random", 8'($urandom), 8'($urandom), 3'b010);
    // High nibble overrides opposite low nibble
    wideCheck("R5 high overrides", 8'h2F, 8'h30, 3'b010);
    wideCheck("R5 high overrides", 8'h30, 8'h2F, 3'b010);
    // Full width used: top bit alone decides
    wideCheck("R6 top bit", 8'h80, 8'h7F, 3'b010);
    wideCheck("R6 top bit", 8'h7F, 8'h80, 3'b010);
    wideCheck("R6 all ones", 8'hFF, 8'hFF, 3'b010);
    // Whole chain cascaded: relation inputs pass only on equality
    wideCheck("R1 chain cascade", 8'hA5, 8'hA5, 3'b100);
    wideCheck("R2 chain cascade", 8'hA5, 8'hA5, 3'b001);
    wideCheck("R7 chain pass illegal", 8'h5A, 8'h5A, 3'b111);
    wideCheck("R7 chain pass zero", 8'h5A, 8'h5A, 3'b000);
    wideCheck("R7 chain ignored", 8'h5B, 8'h5A, 3'b111);
    wideCheck("R7 chain ignored", 8'h59, 8'h5A, 3'b000);

    finish();
  end
endmodule